// File: doc/BRIEF.md
# Byte-Wide Asynchronous Slave Port

This block lets an external bus master exchange single bytes with on-chip firmware over an 8-bit data bus controlled by three active-low lines: a select, a read strobe and a write strobe. Firmware and the master communicate through two one-byte latches. Firmware fills the outbound latch and the master reads it. The master fills the inbound latch and firmware reads it.

The external lines are asynchronous to the block clock, so they pass through two-flop synchronizers first. A free-running four-phase sequencer times every flag update. A transfer is counted as finished when its strobe or the select is released, not when it is asserted. The flags that mark the end of a transfer change only on the fourth phase, and that phase must come after the next second phase following the release.

The block has status flags for inbound-full, outbound-full and inbound-overrun, plus an interrupt flag whose request output is gated by an enable. Only firmware clears these flags, each through its own dedicated pulse. When the port is switched off, the two full flags are forced low and the strobes are ignored. An overrun flag that is already set survives the switch-off. The block also drives the data bus enable for the pads.

Top module: `bytebus_slave`

## Requirements
- R1: After reset, in_full, out_full, in_ovf, irq_flag, irq and ext_data_oe are all 0.
- R2: An external write is select and write strobe both low. When either line returns high, the inbound latch (fw_rdata) holds the byte that was on ext_data_in, and in_full and irq_flag are set. Neither flag is set within 3 clock cycles of the release, and both are set within 15 cycles.
- R3: in_full is cleared only by a fw_rd_in pulse or by disabling the port. fw_clr_irq and fw_clr_ovf leave it set.
- R4: An external write that begins while in_full is 1 sets in_ovf. in_ovf stays 1, including across fw_rd_in and port disable, until a fw_clr_ovf pulse clears it.
- R5: An external read is select and read strobe both low. When one begins, out_full is cleared within 4 cycles of the strobe falling, before the strobe is released.
- R6: When the select or read strobe of an external read returns high, irq_flag is set. It is not set within 3 cycles of the release and is set within 15 cycles.
- R7: out_full is set by a fw_wr_out pulse, which also loads fw_wdata into the outbound latch. After an external read, out_full stays 0 until the next fw_wr_out.
- R8: While port_en is 0, in_full and out_full read 0, external strobes set no flag, and fw_wr_out does not set out_full.
- R9: irq_flag is cleared only by a fw_clr_irq pulse. irq equals irq_flag when irq_en is 1 and is 0 when irq_en is 0.
- R10: ext_data_oe is 1 exactly when port_en is 1 and ext_cs_n and ext_rd_n are both 0. ext_data_out always shows the outbound latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Port enable |
| irq_en | input | 1 | Interrupt request enable |
| ext_cs_n | input | 1 | External select, active low |
| ext_rd_n | input | 1 | External read strobe, active low |
| ext_wr_n | input | 1 | External write strobe, active low |
| ext_data_in | input | 8 | Bus data from the master |
| ext_data_out | output | 8 | Bus data to the master (outbound latch) |
| ext_data_oe | output | 1 | Pad output enable for the data bus |
| fw_wr_out | input | 1 | Firmware write pulse for the outbound latch |
| fw_wdata | input | 8 | Firmware byte for the outbound latch |
| fw_rd_in | input | 1 | Firmware read pulse for the inbound latch |
| fw_rdata | output | 8 | Inbound latch contents |
| fw_clr_ovf | input | 1 | Firmware pulse that clears in_ovf |
| fw_clr_irq | input | 1 | Firmware pulse that clears irq_flag |
| in_full | output | 1 | Inbound latch holds an unread byte |
| out_full | output | 1 | Outbound latch not yet read by the master |
| in_ovf | output | 1 | Sticky inbound overrun flag |
| irq_flag | output | 1 | Port interrupt flag |
| irq | output | 1 | Gated interrupt request |

## Verification
The hardest situation to reach from the ports is an overrun. It needs a second external write to begin while the first byte is still unread. The stimulus completes one write, waits until in_full is visible, and then starts another write without pulsing fw_rd_in. The bench then disables the port and checks that the overrun flag survives while both full flags drop. Flag timing relative to the hidden phase is bounded from the ports by two checks on each release: a check that the flag is still clear shortly after the release, and a later check that it is set.

// File: rtl/bytebus_pkg.sv
// Shared types for the byte-wide slave port.
// Assumes the phase sequencer advances on every clock.
package bytebus_pkg;
    typedef enum logic [1:0] {
        PH1 = 2'd0,
        PH2 = 2'd1,
        PH3 = 2'd2,
        PH4 = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_WAIT_P2 = 2'd1,
        SQ_WAIT_P4 = 2'd2
    } seq_t;
endpackage

// File: rtl/bytebus_sync.sv
// Multi-bit two-flop synchronizer for asynchronous pad inputs.
// Assumes every bit is independent or quasi-static while it is used.
module bytebus_sync #(
    parameter int          WIDTH    = 1,
    parameter logic [63:0] RST_VAL  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage1;

    // Two flops in series to settle metastable samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL[WIDTH-1:0];
            q_sync <= RST_VAL[WIDTH-1:0];
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/bytebus_phase.sv
// Free-running four-phase sequencer, one phase per clock.
// Assumes the phase starts at phase 1 after reset.
module bytebus_phase
    import bytebus_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase
);
    // Step the phase and wrap after phase 4.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH1;
        else        phase <= phase_t'(phase + 2'd1);
    end
endmodule

// File: rtl/bytebus_xfer.sv
// Tracks one transfer direction. It flags the start of a transfer and
// gives a one-cycle completion pulse on the phase-4 cycle that follows
// the next phase 2 after the transfer is released.
// Assumes the active input is already synchronized and gated by enable.
module bytebus_xfer
    import bytebus_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  logic   active,
    input  phase_t phase,
    output logic   start,
    output logic   done
);
    logic active_q;
    seq_t state;

    assign start = active && !active_q;
    assign done  = en && (state == SQ_WAIT_P4) && (phase == PH4);

    // Remember the previous activity level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) active_q <= 1'b0;
        else               active_q <= active;
    end

    // After a release, wait for phase 2, then for phase 4.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state <= SQ_IDLE;
        end else begin
            unique case (state)
                SQ_IDLE:    if (active_q && !active) state <= SQ_WAIT_P2;
                SQ_WAIT_P2: if (phase == PH2)        state <= SQ_WAIT_P4;
                SQ_WAIT_P4: if (phase == PH4)        state <= SQ_IDLE;
                default:                             state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bytebus_slave.sv
// Byte-wide asynchronous slave port between an external master and firmware.
// Synchronizes the strobes, tracks each direction and keeps the latches,
// status flags and interrupt. Assumes bus data is stable while a write
// strobe is low. Firmware pulses are single-cycle and synchronous.
module bytebus_slave
    import bytebus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port_en,
    input  logic          irq_en,
    input  logic          ext_cs_n,
    input  logic          ext_rd_n,
    input  logic          ext_wr_n,
    input  logic [DW-1:0] ext_data_in,
    output logic [DW-1:0] ext_data_out,
    output logic          ext_data_oe,
    input  logic          fw_wr_out,
    input  logic [DW-1:0] fw_wdata,
    input  logic          fw_rd_in,
    output logic [DW-1:0] fw_rdata,
    input  logic          fw_clr_ovf,
    input  logic          fw_clr_irq,
    output logic          in_full,
    output logic          out_full,
    output logic          in_ovf,
    output logic          irq_flag,
    output logic          irq
);
    localparam int SW      = DW + 3;
    localparam int N_DIR   = 2;
    localparam int DIR_WR  = 0;
    localparam int DIR_RD  = 1;

    logic [SW-1:0]    pads_s;
    logic             cs_s, rd_s, wr_s;
    logic [DW-1:0]    data_s;
    phase_t           phase;
    logic [N_DIR-1:0] act, start, done;
    logic [DW-1:0]    in_lat, out_lat;

    bytebus_sync #(.WIDTH(SW), .RST_VAL({{(64-3){1'b0}}, 3'b111} << DW)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ext_cs_n, ext_rd_n, ext_wr_n, ext_data_in}),
        .q_sync  (pads_s)
    );

    assign {cs_s, rd_s, wr_s, data_s} = pads_s;

    bytebus_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    assign act[DIR_WR] = port_en && !cs_s && !wr_s;
    assign act[DIR_RD] = port_en && !cs_s && !rd_s;

    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
        bytebus_xfer u_xfer (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (port_en),
            .active (act[g]),
            .phase  (phase),
            .start  (start[g]),
            .done   (done[g])
        );
    end

    // Inbound latch follows the bus while the write is active.
    always_ff @(posedge clk) begin
        if (!rst_n)          in_lat <= '0;
        else if (act[DIR_WR]) in_lat <= data_s;
    end

    // Outbound latch loads on every firmware write.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_lat <= '0;
        else if (fw_wr_out) out_lat <= fw_wdata;
    end

    // Inbound-full: set on write completion, cleared by a firmware read.
    always_ff @(posedge clk) begin
        if (!rst_n || !port_en) in_full <= 1'b0;
        else if (done[DIR_WR])  in_full <= 1'b1;
        else if (fw_rd_in)      in_full <= 1'b0;
    end

    // Outbound-full: set by a firmware write, cleared when a read starts.
    always_ff @(posedge clk) begin
        if (!rst_n || !port_en) out_full <= 1'b0;
        else if (fw_wr_out)     out_full <= 1'b1;
        else if (start[DIR_RD]) out_full <= 1'b0;
    end

    // Sticky overrun: a write starting over an unread byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                          in_ovf <= 1'b0;
        else if (start[DIR_WR] && in_full)   in_ovf <= 1'b1;
        else if (fw_clr_ovf)                 in_ovf <= 1'b0;
    end

    // Interrupt flag: set on any completion, cleared by firmware only.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq_flag <= 1'b0;
        else if (|done)      irq_flag <= 1'b1;
        else if (fw_clr_irq) irq_flag <= 1'b0;
    end

    assign irq          = irq_flag && irq_en;
    assign fw_rdata     = in_lat;
    assign ext_data_out = out_lat;
    assign ext_data_oe  = port_en && !ext_cs_n && !ext_rd_n;
endmodule

// File: rtl/bytebus_slave_chk.sv
// Temporal checks for the slave port, bound to every instance.
// Assumes the phase encoding from the package.
module bytebus_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       port_en,
    input logic       fw_wr_out,
    input logic       fw_rd_in,
    input logic       fw_clr_ovf,
    input logic       fw_clr_irq,
    input logic       in_full,
    input logic       out_full,
    input logic       in_ovf,
    input logic       irq_flag,
    input logic [1:0] phase
);
    // R2
    in_full_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_full) |-> $past(phase) == 2'd3);
    // R6
    irq_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(phase) == 2'd3);
    // R3
    in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_full) |-> ($past(fw_rd_in) || !$past(port_en)));
    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ovf) |-> $past(fw_clr_ovf));
    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag) |-> $past(fw_clr_irq));
    // R7
    out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_full) |-> $past(fw_wr_out));
    // R8
    dis_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!port_en) |-> (!in_full && !out_full));
endmodule

bind bytebus_slave bytebus_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_en    (port_en),
    .fw_wr_out  (fw_wr_out),
    .fw_rd_in   (fw_rd_in),
    .fw_clr_ovf (fw_clr_ovf),
    .fw_clr_irq (fw_clr_irq),
    .in_full    (in_full),
    .out_full   (out_full),
    .in_ovf     (in_ovf),
    .irq_flag   (irq_flag),
    .phase      (phase)
);

// File: tb/bytebus_slave_bench.sv
module bytebus_slave_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0, irq_en = 1'b0;
    logic       ext_cs_n = 1'b1, ext_rd_n = 1'b1, ext_wr_n = 1'b1;
    logic [7:0] ext_data_in = '0, fw_wdata = '0;
    logic       fw_wr_out = 0, fw_rd_in = 0, fw_clr_ovf = 0, fw_clr_irq = 0;
    logic [7:0] ext_data_out, fw_rdata;
    logic       ext_data_oe, in_full, out_full, in_ovf, irq_flag, irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bytebus_slave u_bytebus_slave (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .irq_en(irq_en),
        .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
        .ext_data_in(ext_data_in), .ext_data_out(ext_data_out),
        .ext_data_oe(ext_data_oe), .fw_wr_out(fw_wr_out), .fw_wdata(fw_wdata),
        .fw_rd_in(fw_rd_in), .fw_rdata(fw_rdata), .fw_clr_ovf(fw_clr_ovf),
        .fw_clr_irq(fw_clr_irq), .in_full(in_full), .out_full(out_full),
        .in_ovf(in_ovf), .irq_flag(irq_flag), .irq(irq)
    );

    // {is_read, byte}
    localparam logic [8:0] VEC [8] = '{
        9'h0A5, 9'h13C, 9'h000, 9'h1FF, 9'h0FF, 9'h100, 9'h05A, 9'h1C3
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    task automatic fw_write(input logic [7:0] d);
        @(negedge clk); fw_wdata = d; fw_wr_out = 1'b1;
        @(negedge clk); fw_wr_out = 1'b0;
    endtask

    task automatic ext_write(input logic [7:0] d);
        @(negedge clk); ext_cs_n = 0; ext_wr_n = 0; ext_data_in = d;
        waitn(6);
        ext_cs_n = 1; ext_wr_n = 1;
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        waitn(3);
        // R1 reset state
        chk({in_full, out_full, in_ovf, irq_flag, irq, ext_data_oe}, 8'h00, "R1 reset flags");
        rst_n = 1'b1; port_en = 1'b1; irq_en = 1'b1;
        waitn(2);

        foreach (VEC[k]) begin
            if (!VEC[k][8]) begin
                ext_write(VEC[k][7:0]);
                waitn(3);
                chk({in_full, irq_flag}, 8'h0, "R2 no early flags");
                waitn(12);
                chk({in_full, irq_flag}, 8'h3, "R2 write flags");
                chk(fw_rdata, VEC[k][7:0], "R2 inbound data");
                chk(irq, 1'b1, "R9 irq gated on");
                pulse(fw_rd_in);
                chk(in_full, 1'b0, "R3 cleared by fw read");
            end else begin
                fw_write(VEC[k][7:0]);
                chk(out_full, 1'b1, "R7 set by fw write");
                @(negedge clk); ext_cs_n = 0; ext_rd_n = 0;
                #1;
                chk(ext_data_oe, 1'b1, "R10 oe on read");
                chk(ext_data_out, VEC[k][7:0], "R10 bus data");
                waitn(4);
                chk(out_full, 1'b0, "R5 cleared at read start");
                ext_cs_n = 1; ext_rd_n = 1;
                #1;
                chk(ext_data_oe, 1'b0, "R10 oe off");
                waitn(3);
                chk(irq_flag, 1'b0, "R6 no early irq");
                waitn(12);
                chk(irq_flag, 1'b1, "R6 read irq");
                chk(out_full, 1'b0, "R7 stays clear");
            end
            pulse(fw_clr_irq);
            chk(irq_flag, 1'b0, "R9 cleared by fw");
        end

        // R3 / R4 overrun and sticky behaviour
        ext_write(8'h11);
        waitn(15);
        chk(in_full, 1'b1, "R2 first write");
        pulse(fw_clr_irq);
        pulse(fw_clr_ovf);
        chk(in_full, 1'b1, "R3 not cleared by other pulses");
        ext_write(8'h22);
        waitn(15);
        chk(in_ovf, 1'b1, "R4 overrun set");
        chk(fw_rdata, 8'h22, "R2 second byte");
        pulse(fw_rd_in);
        chk(in_ovf, 1'b1, "R4 survives fw read");
        pulse(fw_clr_irq);

        // R8 disable
        ext_write(8'h33);
        waitn(15);
        port_en = 1'b0;
        waitn(2);
        chk({in_full, out_full}, 8'h0, "R8 flags held clear");
        chk(in_ovf, 1'b1, "R4 survives disable");
        pulse(fw_clr_irq);
        pulse(fw_clr_ovf);
        chk(in_ovf, 1'b0, "R4 cleared by fw");
        fw_write(8'h44);
        chk(out_full, 1'b0, "R8 fw write ignored");
        ext_write(8'h55);
        waitn(15);
        chk({in_full, irq_flag}, 8'h0, "R8 strobes ignored");
        @(negedge clk); ext_cs_n = 0; ext_rd_n = 0;
        #1;
        chk(ext_data_oe, 1'b0, "R10 oe off when disabled");
        ext_cs_n = 1; ext_rd_n = 1;
        waitn(15);
        chk(irq_flag, 1'b0, "R8 read ignored");

        // R9 gating
        port_en = 1'b1; irq_en = 1'b0;
        waitn(2);
        ext_write(8'h66);
        waitn(15);
        chk({irq_flag, irq}, 8'h2, "R9 request masked");
        irq_en = 1'b1;
        #1;
        chk(irq, 1'b1, "R9 request unmasked");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule